// File: doc/BRIEF.md
# Quadrature Count-Strobe Decoder

This block serves one encoder axis. It takes two phase inputs and a pair of external pulse inputs. From them it produces single-cycle count-up and count-down strobes for a counter that sits downstream. A 3-bit mode input picks one of eight behaviours:

- pass-through of the external up/down pulses;
- x1, x2 or x4 direction discrimination, on phase A, phase B or both;
- gated pulse-width counting;
- gated frequency counting.

The counter that consumes the strobes is not part of this block.

All four inputs run through a two-stage synchronizer on the system clock. Edges are then found by comparing the synchronized phases with the phase pair seen one cycle before. That previous pair is held in a four-state register:

| State | Phase pair {A,B} |
|---|---|
| `PH_00` | 0,0 |
| `PH_10` | 1,0 |
| `PH_11` | 1,1 |
| `PH_01` | 0,1 |

The forward ring runs `PH_00 -> PH_10 -> PH_11 -> PH_01 -> PH_00`, so A leads B. The reverse ring runs the other way. Each move between states is classed as one of:

- a forward step;
- a backward step;
- a hold, where the state is unchanged;
- a jump, where both phases change together.

A hold or a jump never counts. The strobes are registered. A level sampled by the clock at edge n shows on the strobes after edge n+2. An active-low asynchronous reset clears every flip-flop to zero.

Top module: `quad_strobe_dec`

## Requirements
- R1: With mode 000, `ext_sel` is 1 and is 0 in every other mode. A synchronized rising edge on `ext_up` gives one `cnt_up` pulse. A synchronized rising edge on `ext_dn` gives one `cnt_dn` pulse. Rising edges on both in the same cycle give nothing. In modes 001 to 111 the external inputs have no effect on the strobes.
- R2: Mode 001 (x1 on A): `cnt_up` when A rises while B is 0, and `cnt_dn` when A falls while B is 0. No other change counts.
- R3: Mode 010 (x1 on B): `cnt_up` when B rises while A is 1, and `cnt_dn` when B falls while A is 1. No other change counts.
- R4: Mode 011 counts every lone A edge and mode 100 counts every lone B edge. The direction is up for a step along the forward ring and down for a step along the reverse ring.
- R5: Mode 101 counts every lone edge of either phase, up for a forward step and down for a backward step.
- R6: In modes 001 to 101 a cycle in which both synchronized phases change together gives no strobe. As a result, holding both phases high through reset gives no count after reset.
- R7: Mode 110: while synchronized A is 1, a strobe is given on every clock. It is `cnt_up` when synchronized B is 1 and `cnt_dn` when it is 0. While A is 0 there are no strobes.
- R8: Mode 111: `cnt_up` on each synchronized rising edge of A while synchronized B is 1. `cnt_dn` is never given.
- R9: `cnt_up` and `cnt_dn` are never 1 in the same cycle.
- R10: While `rst_n` is 0 both strobes are 0. An input level sampled at clock edge n affects the strobes right after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| mode | input | 3 | behaviour select, 000 to 111 |
| ph_a | input | 1 | phase A / gate (mode 110) / counted signal (mode 111) |
| ph_b | input | 1 | phase B / direction (mode 110) / gate (mode 111) |
| ext_up | input | 1 | external up pulse, used in mode 000 |
| ext_dn | input | 1 | external down pulse, used in mode 000 |
| cnt_up | output | 1 | one-cycle count-up strobe |
| cnt_dn | output | 1 | one-cycle count-down strobe |
| ext_sel | output | 1 | 1 when the external pulse inputs are in use |

## Verification
Each decoding mode is driven with the same set of patterns:

- slow forward rotation, which shows the resolution and which edge positions count;
- the reverse rotation, which separates up from down;
- back-to-back single-cycle steps, which expose any dependence on hold time;
- diagonal jumps, which show that simultaneous phase changes are rejected.

In the external mode, separate, overlapping and simultaneous pulses are applied while the phases also toggle. The phases must have no effect there, and ext pulses must have no effect in the other modes. The gated modes are exercised by:

- toggling the gate with direction high and low (mode 110);
- running a fast signal with the gate open and then shut (mode 111).

Holding both phases high through reset tests the reset corner case.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

    typedef enum logic [2:0] {
        MD_EXT    = 3'd0,
        MD_X1A    = 3'd1,
        MD_X1B    = 3'd2,
        MD_X2A    = 3'd3,
        MD_X2B    = 3'd4,
        MD_X4     = 3'd5,
        MD_PWIDTH = 3'd6,
        MD_FREQ   = 3'd7
    } qmode_e;

    // encoding is {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_FWD  = 2'd1,
        MV_BWD  = 2'd2,
        MV_JUMP = 2'd3
    } move_e;

endpackage

// File: rtl/qsd_sync.sv
module qsd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/qsd_phase_fsm.sv
module qsd_phase_fsm
    import qsd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  qmode_e mode,
    input  logic   a_s,
    input  logic   b_s,
    input  logic   eu_s,
    input  logic   ed_s,
    output logic   up,
    output logic   dn
);
    phase_e     state, next_ph;
    move_e      move;
    logic       a_mv, b_mv;
    logic [1:0] ext_prev;
    logic       eu_rise, ed_rise;
    logic       up_d, dn_d;

    assign next_ph = phase_e'({a_s, b_s});

    // state register: previous synchronized phase pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_00;
            ext_prev <= 2'b00;
        end else begin
            state    <= next_ph;
            ext_prev <= {eu_s, ed_s};
        end
    end

    // classify the transition along the forward ring 00->10->11->01->00
    always_comb begin
        move = MV_JUMP;
        unique case (state)
            PH_00: move = (next_ph == PH_00) ? MV_HOLD :
                          (next_ph == PH_10) ? MV_FWD  :
                          (next_ph == PH_01) ? MV_BWD  : MV_JUMP;
            PH_10: move = (next_ph == PH_10) ? MV_HOLD :
                          (next_ph == PH_11) ? MV_FWD  :
                          (next_ph == PH_00) ? MV_BWD  : MV_JUMP;
            PH_11: move = (next_ph == PH_11) ? MV_HOLD :
                          (next_ph == PH_01) ? MV_FWD  :
                          (next_ph == PH_10) ? MV_BWD  : MV_JUMP;
            PH_01: move = (next_ph == PH_01) ? MV_HOLD :
                          (next_ph == PH_00) ? MV_FWD  :
                          (next_ph == PH_11) ? MV_BWD  : MV_JUMP;
        endcase
    end

    assign a_mv    = (state[1] != a_s) && (move != MV_JUMP);
    assign b_mv    = (state[0] != b_s) && (move != MV_JUMP);
    assign eu_rise = eu_s && !ext_prev[1];
    assign ed_rise = ed_s && !ext_prev[0];

    // output decode per mode
    always_comb begin
        up_d = 1'b0;
        dn_d = 1'b0;
        unique case (mode)
            MD_EXT: begin
                up_d = eu_rise && !ed_rise;
                dn_d = ed_rise && !eu_rise;
            end
            MD_X1A: begin
                up_d = a_mv && !b_s && (move == MV_FWD);
                dn_d = a_mv && !b_s && (move == MV_BWD);
            end
            MD_X1B: begin
                up_d = b_mv && a_s && (move == MV_FWD);
                dn_d = b_mv && a_s && (move == MV_BWD);
            end
            MD_X2A: begin
                up_d = a_mv && (move == MV_FWD);
                dn_d = a_mv && (move == MV_BWD);
            end
            MD_X2B: begin
                up_d = b_mv && (move == MV_FWD);
                dn_d = b_mv && (move == MV_BWD);
            end
            MD_X4: begin
                up_d = (move == MV_FWD);
                dn_d = (move == MV_BWD);
            end
            MD_PWIDTH: begin
                up_d = a_s && b_s;
                dn_d = a_s && !b_s;
            end
            MD_FREQ: begin
                up_d = b_s && a_s && !state[1];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_d;
            dn <= dn_d;
        end
    end
endmodule

// File: rtl/quad_strobe_dec.sv
module quad_strobe_dec
    import qsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       ph_a,
    input  logic       ph_b,
    input  logic       ext_up,
    input  logic       ext_dn,
    output logic       cnt_up,
    output logic       cnt_dn,
    output logic       ext_sel
);
    localparam int NIN = 4;

    logic [NIN-1:0] raw_in, sync_in;
    logic           a_sync, b_sync, eu_sync, ed_sync;
    qmode_e         mode_e;

    assign raw_in = {ph_a, ph_b, ext_up, ext_dn};
    assign {a_sync, b_sync, eu_sync, ed_sync} = sync_in;
    assign mode_e  = qmode_e'(mode);
    assign ext_sel = (mode_e == MD_EXT);

    qsd_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    qsd_phase_fsm fsm_i (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode_e),
        .a_s  (a_sync),
        .b_s  (b_sync),
        .eu_s (eu_sync),
        .ed_s (ed_sync),
        .up   (cnt_up),
        .dn   (cnt_dn)
    );
endmodule

// File: rtl/qsd_chk.sv
module qsd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       a_s,
    input logic       cnt_up,
    input logic       cnt_dn
);
    // R9
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn));

    // R8
    freq_no_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd7) |-> !cnt_dn);

    // R2
    x1a_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_up && $past(mode) == 3'd1 && mode == 3'd1) |=> !cnt_up);

    // R7
    pwidth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && a_s) |=> (cnt_up || cnt_dn));

    // R10
    always @(posedge clk) begin
        if (!rst_n) reset_quiet_chk: assert (!cnt_up && !cnt_dn);
    end
endmodule

bind quad_strobe_dec qsd_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .a_s   (a_sync),
    .cnt_up(cnt_up),
    .cnt_dn(cnt_dn)
);

// File: tb/quad_strobe_dec_tb_top.sv
`timescale 1ns/1ps
module quad_strobe_dec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd5;
    logic       ph_a = 1'b1, ph_b = 1'b1, ext_up = 1'b0, ext_dn = 1'b0;
    logic       cnt_up, cnt_dn, ext_sel;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 0;

    always #2.5 clk = ~clk;

    quad_strobe_dec dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ph_a(ph_a), .ph_b(ph_b),
        .ext_up(ext_up), .ext_dn(ext_dn),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .ext_sel(ext_sel)
    );

    // behavioural reference: history of samples, bit0 = sampled one edge ago
    logic [3:0] ha, hb, hu, hd;
    logic       exp_up, exp_dn;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ha <= '0; hb <= '0; hu <= '0; hd <= '0;
            exp_up <= 1'b0; exp_dn <= 1'b0;
        end else begin
            logic ca, pa, cb, pb, ar, af, br, bf, fwd_a, fwd_b, lone_a, lone_b, u, d;
            ca = ha[1]; pa = ha[2]; cb = hb[1]; pb = hb[2];
            ar = ca && !pa; af = !ca && pa; br = cb && !pb; bf = !cb && pb;
            lone_a = (ar || af) && (cb == pb);
            lone_b = (br || bf) && (ca == pa);
            fwd_a  = ca ^ cb;
            fwd_b  = (ca == cb);
            u = 0; d = 0;
            case (mode)
                3'd0: begin // R1
                    u = hu[1] && !hu[2] && !(hd[1] && !hd[2]);
                    d = hd[1] && !hd[2] && !(hu[1] && !hu[2]);
                end
                3'd1: begin u = lone_a && ar && !cb; d = lone_a && af && !cb; end // R2
                3'd2: begin u = lone_b && br && ca;  d = lone_b && bf && ca;  end // R3
                3'd3: begin u = lone_a && fwd_a; d = lone_a && !fwd_a; end       // R4
                3'd4: begin u = lone_b && fwd_b; d = lone_b && !fwd_b; end       // R4
                3'd5: begin                                                       // R5
                    u = (lone_a && fwd_a) || (lone_b && fwd_b);
                    d = (lone_a && !fwd_a) || (lone_b && !fwd_b);
                end
                3'd6: begin u = ca && cb; d = ca && !cb; end                     // R7
                default: begin u = ar && cb; end                                 // R8
            endcase
            exp_up <= u; exp_dn <= d;
            ha <= {ha[2:0], ph_a}; hb <= {hb[2:0], ph_b};
            hu <= {hu[2:0], ext_up}; hd <= {hd[2:0], ext_dn};
        end
    end

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // per-cycle comparison, between posedge and negedge
    logic [2:0] mode_prev;
    always @(posedge clk) begin
        mode_prev = mode;
        #2;
        if (rst_n && !done) begin
            vectors++;
            if (cnt_up !== exp_up || cnt_dn !== exp_dn) begin
                fails++;
                $display("FAIL %s mode=%0d up/dn act=%b%b exp=%b%b at %0t",
                         req_of(mode_prev), mode_prev, cnt_up, cnt_dn, exp_up, exp_dn, $time);
            end
            if (cnt_up && cnt_dn) begin
                fails++;
                $display("FAIL R9 both strobes act=11 exp=not 11");
            end
            if (ext_sel !== (mode == 3'd0)) begin
                fails++;
                $display("FAIL R1 ext_sel act=%b exp=%b", ext_sel, (mode == 3'd0));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quad(input bit fwd, input int steps, input int hold);
        for (int i = 0; i < steps; i++) begin
            case ({ph_a, ph_b})
                2'b00: {ph_a, ph_b} = fwd ? 2'b10 : 2'b01;
                2'b10: {ph_a, ph_b} = fwd ? 2'b11 : 2'b00;
                2'b11: {ph_a, ph_b} = fwd ? 2'b01 : 2'b10;
                default: {ph_a, ph_b} = fwd ? 2'b00 : 2'b11;
            endcase
            tick(hold);
        end
    endtask

    task automatic check_quiet(input string tag);
        vectors++;
        if (cnt_up !== 1'b0 || cnt_dn !== 1'b0) begin
            fails++;
            $display("FAIL %s reset strobes act=%b%b exp=00", tag, cnt_up, cnt_dn);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    initial begin
        // R10: reset state, with both phases high in mode 5 (R6)
        tick(3);
        #1 check_quiet("R10");
        rst_n = 1'b1;
        tick(8);
        for (int m = 1; m <= 5; m++) begin
            mode = 3'(m);
            tick(4);
            quad(1, 9, 3);
            quad(0, 9, 3);
            quad(1, 8, 1);
            quad(0, 5, 1);
            // R6: diagonal jumps
            {ph_a, ph_b} = ~{ph_a, ph_b}; tick(4);
            {ph_a, ph_b} = ~{ph_a, ph_b}; tick(1);
            {ph_a, ph_b} = ~{ph_a, ph_b}; tick(4);
            // R1: ext pulses ignored outside mode 0
            ext_up = 1; tick(2); ext_up = 0; ext_dn = 1; tick(2); ext_dn = 0; tick(4);
        end
        // R1: external mode
        mode = 3'd0; tick(4);
        ext_up = 1; tick(3); ext_up = 0; tick(3);
        ext_dn = 1; tick(1); ext_dn = 0; tick(3);
        ext_up = 1; ext_dn = 1; tick(3); ext_up = 0; ext_dn = 0; tick(3);
        ext_up = 1; tick(1); ext_dn = 1; tick(2); ext_up = 0; ext_dn = 0; tick(3);
        quad(1, 6, 2); // phases ignored in mode 0
        for (int i = 0; i < 6; i++) begin ext_up = ~ext_up; tick(1); end
        ext_up = 0; tick(4);
        // R7: pulse-width mode
        ph_a = 0; ph_b = 0; tick(4);
        mode = 3'd6; tick(3);
        ph_b = 1; tick(2); ph_a = 1; tick(6); ph_b = 0; tick(5); ph_a = 0; tick(5);
        ph_a = 1; tick(1); ph_a = 0; tick(5);
        // R8: frequency mode
        mode = 3'd7; tick(3);
        for (int i = 0; i < 8; i++) begin ph_a = ~ph_a; tick(1); end
        ph_b = 1;
        for (int i = 0; i < 12; i++) begin ph_a = ~ph_a; tick(2); end
        for (int i = 0; i < 6; i++) begin ph_a = ~ph_a; tick(1); end
        ph_b = 0;
        for (int i = 0; i < 6; i++) begin ph_a = ~ph_a; tick(1); end
        tick(4);
        // R10: reset mid-activity clears strobes at once
        ph_b = 1; ph_a = 1; mode = 3'd6; tick(5);
        rst_n = 0; #1 check_quiet("R10");
        tick(2); check_quiet("R10");
        ph_a = 0; ph_b = 0; tick(1);
        rst_n = 1; tick(6);
        summary();
    end
endmodule